// File: doc/BRIEF.md
# D-PHY Test-Port Configuration Sequencer

This block loads a fixed list of 8-bit configuration registers into a D-PHY through the PHY's serial test port. The port has four wires: a clear line, a strobe clock, an enable flag that marks an address byte, and an 8-bit data bus. A one-cycle start pulse begins a run. The block resets the PHY test logic with one pulse on the clear line. It then writes every register as two strobed phases. The first phase carries the register address with enable high. The second carries the value with enable low.

The register list has three parts, written in this order. First come five clock-lane timing registers. Next come seven timing registers for each active data lane, and the address of each depends on the lane index. Last come six PHY/PLL configuration registers. Two of those six bytes are packed from separate PLL fields. Each level of the strobe is held for a number of system clocks set by an input. A one-cycle done pulse ends the run. The caller keeps the value inputs stable while the block is busy.

Top module: `phy_tst_seq`

## Requirements
- R1: After an accepted start, `tst_clr` is high for exactly H cycles and then low for H cycles before the first strobe. `tst_clk` and `tst_en` stay low while `tst_clr` is high, and `tst_clr` is low at all other times. H is `hold_cycles`, or 1 when that input is 0, sampled at start.
- R2: Each register write opens with an address phase. `tst_data` carries the register address and `tst_en` is 1. `tst_clk` is low for H cycles, then high for H cycles.
- R3: A data phase follows each address phase. `tst_data` carries the value and `tst_en` is 0. `tst_clk` is low for H cycles, then high for H cycles. A run makes exactly two strobe pulses per register, and `tst_data` and `tst_en` do not change while `tst_clk` is high.
- R4: The first five writes target addresses 0x10 through 0x14 in rising order. The write to address 0x10+k carries byte k of `clk_lane_vals` (bits 8k+7:8k).
- R5: For each lane i from 0 to n-1, the block writes addresses 0x20+16*i+k for k = 0..6, in rising k, and each carries byte k of `data_lane_vals`. Here n is `lane_cnt`, with 0 treated as 1 and any value above 4 treated as 4.
- R6: After the lane writes come, in this order: 0x60 with `hstx_sel`, 0x63 with the packed PLL-I byte, 0x64 with `pll_fbd_p`, 0x65 with `pll_fbd_s`, 0x66 with `pll_pre`, and 0x67 with the packed PLL-V byte.
- R7: The PLL-I byte is {2'b00, `pll_div5f`, `pll_div1f`, `pll_fbd_2p`[2:0], `pll_enbwt`}.
- R8: The PLL-V byte is {3'b101, `pll_vco_sel`, `pll_lpf_rs`[1:0], `pll_lpf_cs`[1:0]}.
- R9: Every high level of `tst_clk` lasts exactly H system clocks.
- R10: `done` is high for exactly one cycle. It rises (3+4W)*H cycles after the clock edge that accepts start, where W = 11+7n is the number of writes. `busy` is high from the first cycle after that edge until `done` rises, and low while `done` is high.
- R11: A start pulse that arrives while `busy` is high has no effect. The run ends at the same time, and no new clear pulse or strobe follows `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run when idle |
| lane_cnt | input | 3 | Active data lanes (1..4, clamped) |
| hold_cycles | input | 8 | System clocks per strobe level |
| clk_lane_vals | input | 40 | Five clock-lane timing bytes |
| data_lane_vals | input | 56 | Seven data-lane timing bytes, shared by all lanes |
| hstx_sel | input | 8 | Value for register 0x60 |
| pll_div5f | input | 1 | PLL-I bit 5 |
| pll_div1f | input | 1 | PLL-I bit 4 |
| pll_fbd_2p | input | 3 | PLL-I bits 3:1 |
| pll_enbwt | input | 1 | PLL-I bit 0 |
| pll_fbd_p | input | 8 | Value for register 0x64 |
| pll_fbd_s | input | 8 | Value for register 0x65 |
| pll_pre | input | 8 | Value for register 0x66 |
| pll_vco_sel | input | 1 | PLL-V bit 4 |
| pll_lpf_rs | input | 2 | PLL-V bits 3:2 |
| pll_lpf_cs | input | 2 | PLL-V bits 1:0 |
| tst_clr | output | 1 | PHY test-logic clear |
| tst_clk | output | 1 | Test-port strobe |
| tst_en | output | 1 | High during an address phase |
| tst_data | output | 8 | Test-port data bus |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench sweeps every lane-count code from 0 to 7 against hold settings 0 to 3. It decodes the strobed bus back into address/value pairs and compares them with a list it builds itself. Getting the lane clamp or the lane-advance point wrong would shift every configuration address or truncate the data-lane block. A hold of zero that is not treated as one would make the strobes vanish or the timer wrap, so the done-time arithmetic would fail. A repeated start in the middle of a run must not restart or lengthen it. A design that relatches start would show a second clear pulse or a late done. Field packing is checked with PLL bits that vary from run to run, so a misplaced field shows up as a wrong byte at 0x63 or 0x67.

// File: rtl/phy_tst_pkg.sv
package phy_tst_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_CLR_HI, ST_CLR_LO, ST_A_SET, ST_A_HI, ST_D_SET, ST_D_HI, ST_END
    } seq_st_t;

    typedef enum logic [1:0] { G_CLK, G_DATA, G_CFG } grp_t;

    localparam logic [7:0] CLK_BASE    = 8'h10;
    localparam logic [7:0] DATA_BASE   = 8'h20;
    localparam int         LANE_STRIDE = 16;
    localparam logic [7:0] CFG_FIRST   = 8'h60;
    localparam logic [7:0] PLL_BASE    = 8'h62;
    localparam int         CLK_REGS    = 5;
    localparam int         DATA_REGS   = 7;
    localparam int         CFG_REGS    = 6;
endpackage

// File: rtl/phy_tst_hold_timer.sv
module phy_tst_hold_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic [W-1:0] len,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (restart)
            cnt_d = len - 1'b1;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/phy_tst_regmap.sv
module phy_tst_regmap
    import phy_tst_pkg::*;
#(
    parameter int LANE_W = 2
) (
    input  grp_t              grp,
    input  logic [LANE_W-1:0] lane,
    input  logic [2:0]        item,
    input  logic [39:0]       clk_lane_vals,
    input  logic [55:0]       data_lane_vals,
    input  logic [7:0]        hstx_sel,
    input  logic              pll_div5f,
    input  logic              pll_div1f,
    input  logic [2:0]        pll_fbd_2p,
    input  logic              pll_enbwt,
    input  logic [7:0]        pll_fbd_p,
    input  logic [7:0]        pll_fbd_s,
    input  logic [7:0]        pll_pre,
    input  logic              pll_vco_sel,
    input  logic [1:0]        pll_lpf_rs,
    input  logic [1:0]        pll_lpf_cs,
    output logic [7:0]        addr,
    output logic [7:0]        val
);
    logic [7:0] pll_i_byte, pll_v_byte;
    logic [7:0] clk_byte [CLK_REGS];
    logic [7:0] data_byte [DATA_REGS];

    // R7 / R8: packed PLL bytes
    assign pll_i_byte = {2'b00, pll_div5f, pll_div1f, pll_fbd_2p, pll_enbwt};
    assign pll_v_byte = {3'b101, pll_vco_sel, pll_lpf_rs, pll_lpf_cs};

    for (genvar k = 0; k < CLK_REGS; k++) begin : g_clk_bytes
        assign clk_byte[k] = clk_lane_vals[k*8 +: 8];
    end
    for (genvar k = 0; k < DATA_REGS; k++) begin : g_data_bytes
        assign data_byte[k] = data_lane_vals[k*8 +: 8];
    end

    always_comb begin
        addr = '0;
        val  = '0;
        unique case (grp)
            G_CLK: begin
                addr = CLK_BASE + 8'(item);
                val  = (int'(item) < CLK_REGS) ? clk_byte[item] : 8'h00;
            end
            G_DATA: begin
                addr = DATA_BASE + 8'(int'(lane) * LANE_STRIDE) + 8'(item);
                val  = (int'(item) < DATA_REGS) ? data_byte[item] : 8'h00;
            end
            G_CFG: begin
                addr = (item == 3'd0) ? CFG_FIRST : PLL_BASE + 8'(item);
                case (item)
                    3'd0:    val = hstx_sel;
                    3'd1:    val = pll_i_byte;
                    3'd2:    val = pll_fbd_p;
                    3'd3:    val = pll_fbd_s;
                    3'd4:    val = pll_pre;
                    default: val = pll_v_byte;
                endcase
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/phy_tst_seq.sv
module phy_tst_seq
    import phy_tst_pkg::*;
#(
    parameter int MAX_LANES = 4,
    parameter int HOLD_W    = 8,
    localparam int LANE_W   = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1,
    localparam int LCNT_W   = $clog2(MAX_LANES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LCNT_W-1:0] lane_cnt,
    input  logic [HOLD_W-1:0] hold_cycles,
    input  logic [39:0]       clk_lane_vals,
    input  logic [55:0]       data_lane_vals,
    input  logic [7:0]        hstx_sel,
    input  logic              pll_div5f,
    input  logic              pll_div1f,
    input  logic [2:0]        pll_fbd_2p,
    input  logic              pll_enbwt,
    input  logic [7:0]        pll_fbd_p,
    input  logic [7:0]        pll_fbd_s,
    input  logic [7:0]        pll_pre,
    input  logic              pll_vco_sel,
    input  logic [1:0]        pll_lpf_rs,
    input  logic [1:0]        pll_lpf_cs,
    output logic              tst_clr,
    output logic              tst_clk,
    output logic              tst_en,
    output logic [7:0]        tst_data,
    output logic              busy,
    output logic              done
);
    typedef struct packed {
        seq_st_t           st;
        grp_t              grp;
        logic [LANE_W-1:0] lane;
        logic [2:0]        item;
        logic [LCNT_W-1:0] lanes;
        logic [HOLD_W-1:0] hold;
        logic              done;
    } seq_t;

    seq_t s_d, s_q;
    logic tick, restart, last_write;
    logic [7:0] reg_addr, reg_val;
    logic [LCNT_W-1:0] lanes_eff;
    logic [HOLD_W-1:0] hold_eff;

    // R5: lane count clamp; R9: hold of zero acts as one
    assign lanes_eff = (lane_cnt == '0) ? LCNT_W'(1) :
                       (int'(lane_cnt) > MAX_LANES) ? LCNT_W'(MAX_LANES) : lane_cnt;
    assign hold_eff  = (hold_cycles == '0) ? HOLD_W'(1) : hold_cycles;

    assign last_write = (s_q.grp == G_CFG) && (int'(s_q.item) == CFG_REGS - 1);

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.st)
            ST_IDLE: if (start) begin
                s_d.st    = ST_CLR_HI;
                s_d.lanes = lanes_eff;
                s_d.hold  = hold_eff;
                s_d.grp   = G_CLK;
                s_d.lane  = '0;
                s_d.item  = '0;
            end
            ST_CLR_HI: if (tick) s_d.st = ST_CLR_LO;
            ST_CLR_LO: if (tick) s_d.st = ST_A_SET;
            ST_A_SET:  if (tick) s_d.st = ST_A_HI;
            ST_A_HI:   if (tick) s_d.st = ST_D_SET;
            ST_D_SET:  if (tick) s_d.st = ST_D_HI;
            ST_D_HI: if (tick) begin
                if (last_write) begin
                    s_d.st = ST_END;
                end else begin
                    s_d.st = ST_A_SET;
                    unique case (s_q.grp)
                        G_CLK: if (int'(s_q.item) == CLK_REGS - 1) begin
                            s_d.grp  = G_DATA;
                            s_d.item = '0;
                        end else s_d.item = s_q.item + 1'b1;
                        G_DATA: if (int'(s_q.item) == DATA_REGS - 1) begin
                            s_d.item = '0;
                            if (LCNT_W'(s_q.lane) == s_q.lanes - 1'b1) s_d.grp = G_CFG;
                            else s_d.lane = s_q.lane + 1'b1;
                        end else s_d.item = s_q.item + 1'b1;
                        default: s_d.item = s_q.item + 1'b1;
                    endcase
                end
            end
            ST_END: if (tick) begin
                s_d.st   = ST_IDLE;
                s_d.done = 1'b1;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.st    <= ST_IDLE;
            s_q.grp   <= G_CLK;
            s_q.lanes <= LCNT_W'(1);
            s_q.hold  <= HOLD_W'(1);
        end else begin
            s_q <= s_d;
        end
    end

    assign restart = (s_d.st != s_q.st);

    phy_tst_hold_timer #(.W(HOLD_W)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .len     (s_d.hold),
        .expired (tick)
    );

    phy_tst_regmap #(.LANE_W(LANE_W)) i_regmap (
        .grp            (s_q.grp),
        .lane           (s_q.lane),
        .item           (s_q.item),
        .clk_lane_vals  (clk_lane_vals),
        .data_lane_vals (data_lane_vals),
        .hstx_sel       (hstx_sel),
        .pll_div5f      (pll_div5f),
        .pll_div1f      (pll_div1f),
        .pll_fbd_2p     (pll_fbd_2p),
        .pll_enbwt      (pll_enbwt),
        .pll_fbd_p      (pll_fbd_p),
        .pll_fbd_s      (pll_fbd_s),
        .pll_pre        (pll_pre),
        .pll_vco_sel    (pll_vco_sel),
        .pll_lpf_rs     (pll_lpf_rs),
        .pll_lpf_cs     (pll_lpf_cs),
        .addr           (reg_addr),
        .val            (reg_val)
    );

    always_comb begin
        tst_clr  = (s_q.st == ST_CLR_HI);
        tst_clk  = (s_q.st == ST_A_HI) || (s_q.st == ST_D_HI);
        tst_en   = (s_q.st == ST_A_SET) || (s_q.st == ST_A_HI);
        tst_data = tst_en ? reg_addr :
                   ((s_q.st == ST_D_SET) || (s_q.st == ST_D_HI)) ? reg_val : 8'h00;
    end

    assign busy = (s_q.st != ST_IDLE);
    assign done = s_q.done;

    // R1
    clr_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tst_clr |-> (!tst_clk && !tst_en));
    // R3
    strobe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tst_clk && $past(tst_clk)) |-> ($stable(tst_data) && $stable(tst_en)));
    // R5
    lane_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (s_q.lanes != '0 && int'(s_q.lanes) <= MAX_LANES
                  && LCNT_W'(s_q.lane) < s_q.lanes));
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R11
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && s_q.st != ST_END) |=> busy);
endmodule

// File: tb/test_phy_tst_seq.sv
module test_phy_tst_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] lane_cnt = '0;
    logic [7:0] hold_cycles = '0;
    logic [39:0] clk_lane_vals = '0;
    logic [55:0] data_lane_vals = '0;
    logic [7:0] hstx_sel = '0, pll_fbd_p = '0, pll_fbd_s = '0, pll_pre = '0;
    logic pll_div5f = 0, pll_div1f = 0, pll_enbwt = 0, pll_vco_sel = 0;
    logic [2:0] pll_fbd_2p = '0;
    logic [1:0] pll_lpf_rs = '0, pll_lpf_cs = '0;
    logic tst_clr, tst_clk, tst_en, busy, done;
    logic [7:0] tst_data;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    phy_tst_seq i_phy_tst_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .lane_cnt(lane_cnt),
        .hold_cycles(hold_cycles), .clk_lane_vals(clk_lane_vals),
        .data_lane_vals(data_lane_vals), .hstx_sel(hstx_sel),
        .pll_div5f(pll_div5f), .pll_div1f(pll_div1f), .pll_fbd_2p(pll_fbd_2p),
        .pll_enbwt(pll_enbwt), .pll_fbd_p(pll_fbd_p), .pll_fbd_s(pll_fbd_s),
        .pll_pre(pll_pre), .pll_vco_sel(pll_vco_sel), .pll_lpf_rs(pll_lpf_rs),
        .pll_lpf_cs(pll_lpf_cs), .tst_clr(tst_clr), .tst_clk(tst_clk),
        .tst_en(tst_en), .tst_data(tst_data), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input int l, input int h, input int r);
        int n, hh, nw, idx, clr_cnt, clr_late, nrise, hi_len, hold_err;
        int done_idx, done_cnt, after_act, busy_err;
        int exp_a [64];
        int exp_v [64];
        int exp_g [64];
        int rise_en [128];
        int rise_d [128];
        int gerr [4:8];
        int en_err2, en_err3;
        bit prev_clk;
        n  = (l == 0) ? 1 : ((l > 4) ? 4 : l);
        hh = (h == 0) ? 1 : h;
        nw = 11 + 7 * n;
        lane_cnt    = 3'(l);
        hold_cycles = 8'(h);
        for (int k = 0; k < 5; k++) clk_lane_vals[k*8 +: 8] = 8'((r * 29 + k * 7 + 1) & 255);
        for (int k = 0; k < 7; k++) data_lane_vals[k*8 +: 8] = 8'((r * 53 + k * 13 + 5) & 255);
        hstx_sel = 8'((r * 17 + 3) & 255);
        pll_fbd_p = 8'((r * 5 + 9) & 255);
        pll_fbd_s = 8'((r * 11 + 2) & 255);
        pll_pre   = 8'((r * 19 + 7) & 255);
        pll_div5f = r[0]; pll_div1f = r[1]; pll_enbwt = r[2]; pll_vco_sel = r[3];
        pll_fbd_2p = 3'((r * 3) & 7);
        pll_lpf_rs = 2'(r & 3); pll_lpf_cs = 2'((r >> 1) & 3);
        // expected write list
        for (int k = 0; k < 5; k++) begin
            exp_a[k] = 16 + k; exp_v[k] = (r * 29 + k * 7 + 1) & 255; exp_g[k] = 4;
        end
        for (int i = 0; i < n; i++)
            for (int k = 0; k < 7; k++) begin
                exp_a[5 + i*7 + k] = 32 + 16 * i + k;
                exp_v[5 + i*7 + k] = (r * 53 + k * 13 + 5) & 255;
                exp_g[5 + i*7 + k] = 5;
            end
        idx = 5 + 7 * n;
        exp_a[idx]   = 'h60; exp_v[idx]   = (r * 17 + 3) & 255;  exp_g[idx]   = 6;
        exp_a[idx+1] = 'h63; exp_g[idx+1] = 7;
        exp_v[idx+1] = r[0] * 32 + r[1] * 16 + ((r * 3) & 7) * 2 + r[2];
        exp_a[idx+2] = 'h64; exp_v[idx+2] = (r * 5 + 9) & 255;   exp_g[idx+2] = 6;
        exp_a[idx+3] = 'h65; exp_v[idx+3] = (r * 11 + 2) & 255;  exp_g[idx+3] = 6;
        exp_a[idx+4] = 'h66; exp_v[idx+4] = (r * 19 + 7) & 255;  exp_g[idx+4] = 6;
        exp_a[idx+5] = 'h67; exp_g[idx+5] = 8;
        exp_v[idx+5] = 5 * 32 + r[3] * 16 + (r & 3) * 4 + ((r >> 1) & 3);

        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        idx = 1; clr_cnt = 0; clr_late = 0; nrise = 0; hi_len = 0; hold_err = 0;
        done_idx = -1; done_cnt = 0; after_act = 0; busy_err = 0; prev_clk = 0;
        while (idx < 3000) begin
            if (tst_clr) begin
                clr_cnt++;
                if (nrise > 0 || done_idx >= 0) clr_late++;
            end
            if (tst_clk && !prev_clk && nrise < 128) begin
                rise_en[nrise] = int'(tst_en);
                rise_d[nrise]  = int'(tst_data);
                nrise++;
            end
            if (!tst_clk && prev_clk && hi_len != hh) hold_err++;
            hi_len = tst_clk ? hi_len + 1 : 0;
            prev_clk = tst_clk;
            if (done) begin
                done_cnt++;
                if (done_idx < 0) done_idx = idx;
                if (busy) busy_err++;
            end else if (done_idx < 0 && !busy) busy_err++;
            if (done_idx >= 0 && idx > done_idx && (tst_clr || tst_clk || busy)) after_act++;
            if (done_idx >= 0 && idx >= done_idx + 10) break;
            start = (idx == 5);
            idx++;
            @(negedge clk);
        end
        start = 1'b0;
        check(clr_cnt == hh && clr_late == 0, "R1 clear pulse", clr_cnt, hh);
        check(nrise == 2 * nw, "R3 strobe count", nrise, 2 * nw);
        en_err2 = 0; en_err3 = 0;
        for (int g = 4; g <= 8; g++) gerr[g] = 0;
        for (int j = 0; j < nw && 2*j+1 < nrise; j++) begin
            if (rise_en[2*j] != 1) en_err2++;
            if (rise_en[2*j+1] != 0) en_err3++;
            if (rise_d[2*j] != exp_a[j] || rise_d[2*j+1] != exp_v[j]) gerr[exp_g[j]]++;
        end
        check(en_err2 == 0, "R2 address phase enable", en_err2, 0);
        check(en_err3 == 0, "R3 data phase enable", en_err3, 0);
        check(gerr[4] == 0, "R4 clock-lane writes", gerr[4], 0);
        check(gerr[5] == 0, "R5 data-lane writes", gerr[5], 0);
        check(gerr[6] == 0, "R6 config writes", gerr[6], 0);
        check(gerr[7] == 0, "R7 PLL-I packing", gerr[7], 0);
        check(gerr[8] == 0, "R8 PLL-V packing", gerr[8], 0);
        check(hold_err == 0, "R9 strobe high length", hold_err, 0);
        check(done_idx == (3 + 4 * nw) * hh + 1, "R10 done time", done_idx, (3 + 4 * nw) * hh + 1);
        check(done_cnt == 1 && busy_err == 0, "R10 done width/busy", done_cnt * 100 + busy_err, 100);
        check(after_act == 0, "R11 mid-run start ignored", after_act, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(tst_clr == 0 && tst_clk == 0 && tst_en == 0 && busy == 0 && done == 0,
              "R1 reset state", int'({tst_clr, tst_clk, tst_en, busy, done}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(busy == 0 && tst_data == 8'h00, "R10 idle after reset", int'(busy), 0);
        for (int l = 0; l < 8; l++)
            for (int h = 0; h < 4; h++)
                run(l, h, l * 4 + h + 1);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule